// File: doc/BRIEF.md
# Field-Programmable Logic Array

This block is a run-time configurable sum-of-products array. It has `NUM_IN` inputs, `NUM_TERMS` product terms and `NUM_OUT` outputs. Both planes sit in fuse registers. The AND plane holds a two-bit literal code for every input of every product term. The OR plane holds one connect bit per term per output. Each output also has a polarity bit that can invert its sum. The path from `pla_in_i` to `pla_out_o` is purely combinational, and only the programming side is clocked.

A controller loads a program table one entry at a time through a word-wide write port. Each write carries a plane select, a term index, an input or output index and a two-bit value. Once the table is loaded, a lock command freezes the fuses until the next reset, in the way a field-programmed device is committed once. Any product term may feed several outputs, so shared terms cost one AND gate only.

Top module: `pla_array`

## Requirements
- R1: An AND-plane literal code is two bits, with bit 1 the true-input fuse and bit 0 the complement fuse. 2'b10 uses the input as is, 2'b01 uses its complement, 2'b11 leaves the input out of the term (constant 1), and 2'b00 forces the whole term to 0.
- R2: An OR-plane connect bit of 1 ties a product term to an output and 0 leaves it open. Each output is the OR of its connected terms, and an output with no true connected term gives 0 before polarity.
- R3: An output's polarity bit of 0 passes the OR result, and 1 drives its complement.
- R4: After reset every literal code is 2'b11, every connect bit is 1, every polarity bit is 0 and the lock is clear, so every output reads 1 for every input pattern.
- R5: A write is a one-cycle pulse on `prog_we_i`, and it takes effect at that rising edge. Plane code 0 writes literal `prog_data_i` for term `prog_term_i` and input `prog_idx_i`. Plane code 1 writes connect bit `prog_data_i[0]` for term `prog_term_i` to output `prog_idx_i`. Plane code 2 writes polarity bit `prog_data_i[0]` for output `prog_idx_i`. Plane code 3 is the lock command.
- R6: The lock command raises `prog_locked_o` from the next cycle on. After that, every write is ignored until reset.
- R7: A write whose term index or whose input or output index is out of range for its plane changes nothing.
- R8: Outputs follow a change on `pla_in_i` within the same cycle, with no clock edge in between.
- R9: With terms AB, B'C, AC', B'C', A (input 0 = A, 1 = B, 2 = C) the outputs give F0 = A + B'C', F1 = AC' + AB, F2 = B'C' + AB and F3 = B'C + A. This holds over all eight input patterns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Programming clock |
| rst_ni | input | 1 | Asynchronous active-low reset to the unprogrammed state |
| prog_we_i | input | 1 | Write strobe for the programming port |
| prog_plane_i | input | 2 | Target: 0 AND, 1 OR, 2 polarity, 3 lock |
| prog_term_i | input | TW | Product term index |
| prog_idx_i | input | IW | Input index (AND) or output index (OR, polarity) |
| prog_data_i | input | 2 | Literal code or connect/polarity bit in bit 0 |
| prog_locked_o | output | 1 | Fuses frozen |
| pla_in_i | input | NUM_IN | Logic inputs |
| pla_out_o | output | NUM_OUT | Logic outputs |

## Verification
The hardest condition to reach is a write that arrives after the lock while the program is a real, non-trivial table. If such a write slipped through, it must move an output that the checks can see. To set this up, the bench loads the full shared-term program and inverts one output. It then locks the array and issues connect and polarity writes that would visibly change F2 and F1. Finally it sweeps every input pattern against the closed-form equations. A term killed by code 2'b00 is reached the same way: pattern A=1, B=1, C=0 drops both F0 and F3 only if term A is really gone.

// File: rtl/pla_pkg.sv
package pla_pkg;

    typedef enum logic [1:0] {
        SEL_AND  = 2'd0,
        SEL_OR   = 2'd1,
        SEL_POL  = 2'd2,
        SEL_LOCK = 2'd3
    } plane_sel_e;

    localparam logic [1:0] LIT_KILL = 2'b00;
    localparam logic [1:0] LIT_COMP = 2'b01;
    localparam logic [1:0] LIT_TRUE = 2'b10;
    localparam logic [1:0] LIT_FREE = 2'b11;

endpackage

// File: rtl/pla_fuse_store.sv
module pla_fuse_store
    import pla_pkg::*;
#(
    parameter int NUM_IN    = 3,
    parameter int NUM_TERMS = 5,
    parameter int NUM_OUT   = 4,
    parameter int TW        = 3,
    parameter int IW        = 2
) (
    input  logic                                   clk_i,
    input  logic                                   rst_ni,
    input  logic                                   we_i,
    input  logic [1:0]                             plane_i,
    input  logic [TW-1:0]                          term_i,
    input  logic [IW-1:0]                          idx_i,
    input  logic [1:0]                             data_i,
    output logic [NUM_TERMS-1:0][NUM_IN-1:0][1:0]  and_fuse_o,
    output logic [NUM_OUT-1:0][NUM_TERMS-1:0]      or_fuse_o,
    output logic [NUM_OUT-1:0]                     pol_o,
    output logic                                   locked_o
);

    typedef struct packed {
        logic [NUM_TERMS-1:0][NUM_IN-1:0][1:0] and_f;
        logic [NUM_OUT-1:0][NUM_TERMS-1:0]     or_f;
        logic [NUM_OUT-1:0]                    pol;
        logic                                  locked;
    } fuse_t;

    fuse_t st_d, st_q;
    logic  wr_open;

    assign wr_open = we_i && !st_q.locked;

    always_comb begin
        st_d = st_q;
        if (wr_open) begin
            unique case (plane_sel_e'(plane_i))
                SEL_AND: begin
                    for (int t = 0; t < NUM_TERMS; t++) begin
                        for (int i = 0; i < NUM_IN; i++) begin
                            if (int'(term_i) == t && int'(idx_i) == i) begin
                                st_d.and_f[t][i] = data_i;
                            end
                        end
                    end
                end
                SEL_OR: begin
                    for (int o = 0; o < NUM_OUT; o++) begin
                        for (int t = 0; t < NUM_TERMS; t++) begin
                            if (int'(term_i) == t && int'(idx_i) == o) begin
                                st_d.or_f[o][t] = data_i[0];
                            end
                        end
                    end
                end
                SEL_POL: begin
                    for (int o = 0; o < NUM_OUT; o++) begin
                        if (int'(idx_i) == o) begin
                            st_d.pol[o] = data_i[0];
                        end
                    end
                end
                SEL_LOCK: begin
                    st_d.locked = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.and_f  <= '1;
            st_q.or_f   <= '1;
            st_q.pol    <= '0;
            st_q.locked <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign and_fuse_o = st_q.and_f;
    assign or_fuse_o  = st_q.or_f;
    assign pol_o      = st_q.pol;
    assign locked_o   = st_q.locked;

    // R6: a locked array keeps every fuse through any write
    a_r6_locked_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.locked && we_i) |=> $stable(st_q));

    // R6: the lock never clears without reset
    a_r6_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.locked |=> st_q.locked);

    // R6: the lock command takes hold at the next edge
    a_r6_lock_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && plane_i == SEL_LOCK) |=> st_q.locked);

    // R5: an in-range literal write lands in the addressed pair
    a_r5_and_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_open && plane_i == SEL_AND && int'(term_i) < NUM_TERMS && int'(idx_i) < NUM_IN)
        |=> st_q.and_f[$past(term_i)][$past(idx_i)] == $past(data_i));

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane
    import pla_pkg::*;
#(
    parameter int NUM_IN    = 3,
    parameter int NUM_TERMS = 5
) (
    input  logic [NUM_IN-1:0]                      in_i,
    input  logic [NUM_TERMS-1:0][NUM_IN-1:0][1:0]  and_fuse_i,
    output logic [NUM_TERMS-1:0]                   term_o
);

    logic [NUM_TERMS-1:0][NUM_IN-1:0] lit;

    for (genvar t = 0; t < NUM_TERMS; t++) begin : g_term
        for (genvar i = 0; i < NUM_IN; i++) begin : g_lit
            always_comb begin
                unique case (and_fuse_i[t][i])
                    LIT_TRUE: lit[t][i] = in_i[i];
                    LIT_COMP: lit[t][i] = ~in_i[i];
                    LIT_FREE: lit[t][i] = 1'b1;
                    default:  lit[t][i] = 1'b0;
                endcase
            end
        end
        assign term_o[t] = &lit[t];
    end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
    parameter int NUM_TERMS = 5,
    parameter int NUM_OUT   = 4
) (
    input  logic [NUM_TERMS-1:0]               term_i,
    input  logic [NUM_OUT-1:0][NUM_TERMS-1:0]  or_fuse_i,
    input  logic [NUM_OUT-1:0]                 pol_i,
    output logic [NUM_OUT-1:0]                 out_o
);

    for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
        logic sum;
        assign sum      = |(or_fuse_i[o] & term_i);
        assign out_o[o] = sum ^ pol_i[o];
    end

endmodule

// File: rtl/pla_array.sv
module pla_array #(
    parameter int NUM_IN    = 3,
    parameter int NUM_TERMS = 5,
    parameter int NUM_OUT   = 4,
    localparam int MAX_IDX  = (NUM_IN > NUM_OUT) ? NUM_IN : NUM_OUT,
    localparam int TW       = (NUM_TERMS > 1) ? $clog2(NUM_TERMS) : 1,
    localparam int IW       = (MAX_IDX > 1) ? $clog2(MAX_IDX) : 1
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                prog_we_i,
    input  logic [1:0]          prog_plane_i,
    input  logic [TW-1:0]       prog_term_i,
    input  logic [IW-1:0]       prog_idx_i,
    input  logic [1:0]          prog_data_i,
    output logic                prog_locked_o,
    input  logic [NUM_IN-1:0]   pla_in_i,
    output logic [NUM_OUT-1:0]  pla_out_o
);

    logic [NUM_TERMS-1:0][NUM_IN-1:0][1:0] and_fuse;
    logic [NUM_OUT-1:0][NUM_TERMS-1:0]     or_fuse;
    logic [NUM_OUT-1:0]                    pol;
    logic [NUM_TERMS-1:0]                  terms;

    pla_fuse_store #(
        .NUM_IN(NUM_IN), .NUM_TERMS(NUM_TERMS), .NUM_OUT(NUM_OUT), .TW(TW), .IW(IW)
    ) u_store (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .we_i       (prog_we_i),
        .plane_i    (prog_plane_i),
        .term_i     (prog_term_i),
        .idx_i      (prog_idx_i),
        .data_i     (prog_data_i),
        .and_fuse_o (and_fuse),
        .or_fuse_o  (or_fuse),
        .pol_o      (pol),
        .locked_o   (prog_locked_o)
    );

    pla_and_plane #(.NUM_IN(NUM_IN), .NUM_TERMS(NUM_TERMS)) u_and (
        .in_i       (pla_in_i),
        .and_fuse_i (and_fuse),
        .term_o     (terms)
    );

    pla_or_plane #(.NUM_TERMS(NUM_TERMS), .NUM_OUT(NUM_OUT)) u_or (
        .term_i    (terms),
        .or_fuse_i (or_fuse),
        .pol_i     (pol),
        .out_o     (pla_out_o)
    );

    // R2, R3: with no product term true, each output shows only its polarity
    a_r2_idle_terms_give_polarity: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (terms == '0) |-> (pla_out_o == pol));

endmodule

// File: tb/pla_array_bench.sv
module pla_array_bench;
    localparam int NI = 3;
    localparam int NT = 5;
    localparam int NO = 4;
    localparam int TW = 3;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b1;
    logic          we = 1'b0;
    logic [1:0]    plane = '0;
    logic [TW-1:0] term = '0;
    logic [IW-1:0] idx = '0;
    logic [1:0]    data = '0;
    logic          locked;
    logic [NI-1:0] pin = '0;
    logic [NO-1:0] pout;

    always #5 clk = ~clk;

    pla_array u_pla_array (
        .clk_i(clk), .rst_ni(rst_n), .prog_we_i(we), .prog_plane_i(plane),
        .prog_term_i(term), .prog_idx_i(idx), .prog_data_i(data),
        .prog_locked_o(locked), .pla_in_i(pin), .pla_out_o(pout)
    );

    int m_and [NT][NI];
    int m_or  [NO][NT];
    int m_pol [NO];
    int m_lock;
    int n_chk = 0;
    int n_err = 0;
    bit checking = 1'b0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [NO-1:0] model_eval(input logic [NI-1:0] x);
        logic [NO-1:0] r;
        logic [NT-1:0] tv;
        for (int t = 0; t < NT; t++) begin
            tv[t] = 1'b1;
            for (int i = 0; i < NI; i++) begin
                case (m_and[t][i])
                    2: if (!x[i]) tv[t] = 1'b0;
                    1: if (x[i]) tv[t] = 1'b0;
                    0: tv[t] = 1'b0;
                    default: ;
                endcase
            end
        end
        for (int o = 0; o < NO; o++) begin
            r[o] = 1'b0;
            for (int t = 0; t < NT; t++) if (m_or[o][t] != 0 && tv[t]) r[o] = 1'b1;
            if (m_pol[o] != 0) r[o] = ~r[o];
        end
        return r;
    endfunction

    task automatic model_reset();
        for (int t = 0; t < NT; t++) for (int i = 0; i < NI; i++) m_and[t][i] = 3;
        for (int o = 0; o < NO; o++) begin
            m_pol[o] = 0;
            for (int t = 0; t < NT; t++) m_or[o][t] = 1;
        end
        m_lock = 0;
    endtask

    // R5 model compared on every clock
    always @(negedge clk) begin
        if (checking) begin
            chk(pout === model_eval(pin), "R5 per-cycle output", 32'(pout), 32'(model_eval(pin)));
            chk(locked === m_lock[0], "R6 per-cycle lock", 32'(locked), 32'(m_lock));
        end
    end

    task automatic do_reset();
        @(posedge clk); #1;
        checking = 1'b0;
        rst_n = 1'b0;
        model_reset();
        @(posedge clk); #1;
        rst_n = 1'b1;
        checking = 1'b1;
    endtask

    task automatic prog(input int pl, input int tm, input int ix, input int dv);
        @(posedge clk); #1;
        plane = pl[1:0]; term = tm[TW-1:0]; idx = ix[IW-1:0]; data = dv[1:0]; we = 1'b1;
        @(posedge clk); #1;
        we = 1'b0;
        if (m_lock == 0) begin
            case (pl)
                0: if (tm < NT && ix < NI) m_and[tm][ix] = dv;
                1: if (tm < NT && ix < NO) m_or[ix][tm] = dv & 1;
                2: if (ix < NO) m_pol[ix] = dv & 1;
                3: m_lock = 1;
                default: ;
            endcase
        end
    endtask

    // R8: output checked two time units after the input moves, no edge between
    task automatic set_in(input logic [NI-1:0] x);
        @(posedge clk); #1;
        pin = x;
        #2;
        chk(pout === model_eval(x), "R8 same-cycle response", 32'(pout), 32'(model_eval(x)));
    endtask

    task automatic sweep_golden(input string req, input logic [NO-1:0] inv);
        for (int v = 0; v < 8; v++) begin
            logic a, b, c;
            logic [NO-1:0] e;
            set_in(v[NI-1:0]);
            a = v[0]; b = v[1]; c = v[2];
            e[0] = a | (~b & ~c);
            e[1] = (a & ~c) | (a & b);
            e[2] = (~b & ~c) | (a & b);
            e[3] = (~b & c) | a;
            e = e ^ inv;
            chk(pout === e, req, 32'(pout), 32'(e));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int and_tab [NT][NI];
        int or_tab [NO];
        // literal codes: 2 true, 1 complement, 3 free; inputs A,B,C
        and_tab = '{'{2, 2, 3}, '{3, 1, 2}, '{2, 3, 1}, '{3, 1, 1}, '{2, 3, 3}};
        // connect masks per output, bit t = term t
        or_tab = '{5'b11000, 5'b00101, 5'b01001, 5'b10010};

        model_reset();
        do_reset();

        // R4 unprogrammed state
        set_in(3'b000);
        chk(pout === 4'hF, "R4 reset outputs", 32'(pout), 32'hF);
        set_in(3'b101);
        chk(pout === 4'hF, "R4 reset outputs", 32'(pout), 32'hF);
        chk(locked === 1'b0, "R4 reset lock", 32'(locked), 0);

        // R5, R1, R2 load the shared-term program
        for (int t = 0; t < NT; t++) for (int i = 0; i < NI; i++) prog(0, t, i, and_tab[t][i]);
        for (int o = 0; o < NO; o++) for (int t = 0; t < NT; t++) prog(1, t, o, int'(or_tab[o][t]));
        sweep_golden("R9 reference program", 4'b0000);

        // R1 kill code on term A
        prog(0, 4, 0, 0);
        set_in(3'b011);
        chk(pout === 4'b0110, "R1 killed term", 32'(pout), 32'h6);
        prog(0, 4, 0, 2);

        // R3 invert F1
        prog(2, 0, 1, 1);
        sweep_golden("R3 polarity", 4'b0010);

        // R7 out-of-range term and input index
        prog(0, 6, 0, 0);
        prog(0, 0, 3, 0);
        prog(1, 7, 2, 0);
        sweep_golden("R7 ignored writes", 4'b0010);

        // R2 connect B'C to F2, then remove it
        prog(1, 1, 2, 1);
        set_in(3'b100);
        chk(pout === 4'b1110, "R2 added connection", 32'(pout), 32'hE);
        prog(1, 1, 2, 0);

        // R6 lock then attempt writes
        prog(3, 0, 0, 0);
        chk(locked === 1'b1, "R6 lock raised", 32'(locked), 1);
        prog(1, 4, 2, 1);
        prog(2, 0, 1, 0);
        prog(0, 4, 0, 0);
        sweep_golden("R6 writes after lock", 4'b0010);

        // R4 reset clears program and lock, R5 write works again
        do_reset();
        set_in(3'b011);
        chk(pout === 4'hF, "R4 second reset", 32'(pout), 32'hF);
        chk(locked === 1'b0, "R4 lock cleared", 32'(locked), 0);
        prog(2, 0, 0, 1);
        chk(pout === 4'b1110, "R5 polarity write after reset", 32'(pout), 32'hE);

        @(posedge clk); #1;
        done = 1'b1;
        checking = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule